// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Programming Controller

This block sits between requesters and an array of 256 one-time fuse cells. Each cell starts unblown and can only ever move to blown. The cells are treated as abstract sticky bits: the controller drives a burn strobe together with a cell index, and it watches a parallel bus of sense outputs. A requester asks for one fuse index at a time over a valid/ready handshake. For an accepted request the controller burns that single fuse for a programmed number of cycles. It then reads the fuse back and ends the request with a one-cycle done pulse and a two-bit status. A fuse that fails to blow can be retried.

After reset the controller waits a fixed settle time and then copies every sense output into a shadow register. All reads, flags and the lock state come from this copy. The copy is refreshed bit by bit as fuses are verified. The top fuse (index 255) is a write-protect bit. Once the copy shows it blown, every later request is refused. A hide request makes all reads return zero and also refuses burns; only a reset clears it. Fuses 0 to 127 form the signature key field. While that field reads all zero, a flag tells boot logic that any program may run unsigned. Fuses 128 to 254 are a further key or user field with no special handling.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset is released the controller waits 8 cycles and then samples `fuse_sense` into its copy at the 8th rising edge. `fuse_valid` goes high after that edge and stays high. `req_ready` is low while `fuse_valid` is low.
- R2: `req_ready` is high only when the controller is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until after the done pulse. `done` is high for exactly one cycle, and `status` is valid in that cycle.
- R3: An accepted burn drives `fuse_blow` high with `fuse_sel` equal to the requested index for L consecutive cycles, starting after the accepting edge. L is `pulse_cycles`, raised to 1 if it is 0 and capped at CLK_HZ/1000 (50000 by default). Only one fuse is addressed at a time.
- R4: Two cycles after the burn ends, the target sense bit is sampled and `done` rises. Status 0 (ok) means the bit read blown. Status 1 (verify-fail) means it read unblown. The copy of that bit takes the sampled value. The done pulse follows the accepting edge by 1+L+2 edges.
- R5: When bit 255 of the copy is set, `locked` is high. Every later request ends with status 2 (locked) on the edge after acceptance, and no burn is driven.
- R6: A one-cycle `hide_req` sets a hidden state that stays set until reset. While hidden, `rd_data` reads zero. A request that is not locked ends with status 3 (hidden) on the edge after acceptance, with no burn. If both apply, locked wins.
- R7: `key_blank` is high exactly when `fuse_valid` is high and copy bits 0 to 127 are all zero.
- R8: `rd_data` is copy bits `rd_sel*32` to `rd_sel*32+31`, with bit `rd_sel*32` at `rd_data[0]`. It follows `rd_sel` combinationally.
- R9: Reset clears the hidden state and takes a fresh copy of the fuse array after the settle time. Fuses blown before the reset read back blown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burn request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_idx | input | 8 | Fuse index to burn |
| pulse_cycles | input | 16 | Requested burn length in cycles, sampled at acceptance |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | 0 ok, 1 verify-fail, 2 locked, 3 hidden |
| hide_req | input | 1 | Sets the hidden state until reset |
| rd_sel | input | 3 | Read word select |
| rd_data | output | 32 | Selected 32-bit word of the copy, zero while hidden |
| fuse_valid | output | 1 | Copy has been taken since reset |
| key_blank | output | 1 | Signature key field reads all zero |
| locked | output | 1 | Write-protect fuse reads blown |
| fuse_blow | output | 1 | Burn strobe to the fuse cells |
| fuse_sel | output | 8 | Index of the fuse being burned |
| fuse_sense | input | 256 | Sense outputs of all fuse cells |

## Verification
A wrong copy bit shows on the next cycle in which `rd_data` selects its word. It also shows in `key_blank` or `locked` on the cycle after the verify edge. For this reason the bench rotates `rd_sel` every clock and compares all three outputs against its own model every cycle. A wrong burn timer or sequencer state shows as a wrong number of `fuse_blow` cycles or a done pulse on the wrong edge, so every request is timed to the exact edge. A lost hidden or lock state shows as a burn that should have been refused and a wrong status on the very next done pulse.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

    typedef enum logic [1:0] {
        FST_OK     = 2'd0,
        FST_VFAIL  = 2'd1,
        FST_LOCKED = 2'd2,
        FST_HIDDEN = 2'd3
    } fuse_status_e;

    typedef enum logic [2:0] {
        PH_SETTLE,
        PH_IDLE,
        PH_BURN,
        PH_SENSE,
        PH_DONE
    } ctrl_phase_e;

endpackage

// File: rtl/fuse_burn_timer.sv
module fuse_burn_timer #(
    parameter int PULSE_MAX = 50000,
    parameter int PW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] len_req,
    output logic          active,
    output logic          last
);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    // Length 0 becomes 1; anything above the ceiling is held at the ceiling.
    function automatic logic [PW-1:0] clamp_len(input logic [PW-1:0] r);
        if (r == '0)
            return PW'(1);
        else if (r > PW'(PULSE_MAX))
            return PW'(PULSE_MAX);
        else
            return r;
    endfunction

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.active = 1'b1;
            t_d.cnt    = clamp_len(len_req) - PW'(1);
        end else if (t_q.active) begin
            if (t_q.cnt == '0)
                t_d.active = 1'b0;
            else
                t_d.cnt = t_q.cnt - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '0;
        else
            t_q <= t_d;
    end

    assign active = t_q.active;
    assign last   = t_q.active && (t_q.cnt == '0);

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
    parameter int N_FUSES  = 256,
    parameter int KEY_BITS = 128,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 8,
    parameter int SEL_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [N_FUSES-1:0] sense_all,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_val,
    input  logic [SEL_W-1:0]   rd_sel,
    input  logic               hide,
    output logic [WORD_W-1:0]  rd_word,
    output logic               key_zero,
    output logic               wp_bit
);

    localparam int N_WORDS = N_FUSES / WORD_W;

    logic [N_FUSES-1:0] bits_d, bits_q;
    logic [WORD_W-1:0]  word_arr [N_WORDS];

    always_comb begin
        bits_d = bits_q;
        if (capture)
            bits_d = sense_all;
        else if (upd_en)
            bits_d[upd_idx] = upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bits_q <= '0;
        else
            bits_q <= bits_d;
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        assign word_arr[w] = bits_q[w*WORD_W +: WORD_W];
    end

    assign rd_word  = hide ? '0 : word_arr[rd_sel];
    assign key_zero = ~|bits_q[KEY_BITS-1:0];
    assign wp_bit   = bits_q[N_FUSES-1];

endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
    import fuse_prog_pkg::*;
#(
    parameter int N_FUSES    = 256,
    parameter int KEY_BITS   = 128,
    parameter int WORD_W     = 32,
    parameter int CLK_HZ     = 50_000_000,
    parameter int SETTLE_CYC = 8,
    parameter int SENSE_CYC  = 2,
    localparam int IDX_W     = $clog2(N_FUSES),
    localparam int PULSE_MAX = CLK_HZ / 1000,
    localparam int PW        = $clog2(PULSE_MAX + 1),
    localparam int N_WORDS   = N_FUSES / WORD_W,
    localparam int SEL_W     = $clog2(N_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [PW-1:0]      pulse_cycles,
    output logic               done,
    output logic [1:0]         status,
    input  logic               hide_req,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [WORD_W-1:0]  rd_data,
    output logic               fuse_valid,
    output logic               key_blank,
    output logic               locked,
    output logic               fuse_blow,
    output logic [IDX_W-1:0]   fuse_sel,
    input  logic [N_FUSES-1:0] fuse_sense
);

    localparam int CNT_MAX = (SETTLE_CYC > SENSE_CYC) ? SETTLE_CYC : SENSE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        ctrl_phase_e  phase;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        fuse_status_e status;
        logic         hidden;
        logic         valid;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic burn_start, burn_active, burn_last;
    logic capture, upd_en, upd_val;
    logic key_zero, wp_bit;
    logic hide_flag;

    always_comb begin
        c_d        = c_q;
        burn_start = 1'b0;
        capture    = 1'b0;
        upd_en     = 1'b0;
        upd_val    = 1'b0;
        if (hide_req)
            c_d.hidden = 1'b1;
        case (c_q.phase)
            PH_SETTLE: begin
                if (c_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    capture   = 1'b1;
                    c_d.valid = 1'b1;
                    c_d.cnt   = '0;
                    c_d.phase = PH_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt + CNT_W'(1);
                end
            end
            PH_IDLE: begin
                if (req_valid) begin
                    c_d.idx = req_idx;
                    if (wp_bit) begin
                        c_d.status = FST_LOCKED;
                        c_d.phase  = PH_DONE;
                    end else if (c_q.hidden) begin
                        c_d.status = FST_HIDDEN;
                        c_d.phase  = PH_DONE;
                    end else begin
                        burn_start = 1'b1;
                        c_d.phase  = PH_BURN;
                    end
                end
            end
            PH_BURN: begin
                if (burn_last) begin
                    c_d.cnt   = '0;
                    c_d.phase = PH_SENSE;
                end
            end
            PH_SENSE: begin
                if (c_q.cnt == CNT_W'(SENSE_CYC - 1)) begin
                    upd_en     = 1'b1;
                    upd_val    = fuse_sense[c_q.idx];
                    c_d.status = upd_val ? FST_OK : FST_VFAIL;
                    c_d.cnt    = '0;
                    c_d.phase  = PH_DONE;
                end else begin
                    c_d.cnt = c_q.cnt + CNT_W'(1);
                end
            end
            PH_DONE: c_d.phase = PH_IDLE;
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.phase  <= PH_SETTLE;
            c_q.status <= FST_OK;
        end else begin
            c_q <= c_d;
        end
    end

    fuse_burn_timer #(
        .PULSE_MAX (PULSE_MAX),
        .PW        (PW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (burn_start),
        .len_req (pulse_cycles),
        .active  (burn_active),
        .last    (burn_last)
    );

    fuse_shadow_bank #(
        .N_FUSES  (N_FUSES),
        .KEY_BITS (KEY_BITS),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W),
        .SEL_W    (SEL_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .sense_all (fuse_sense),
        .upd_en    (upd_en),
        .upd_idx   (c_q.idx),
        .upd_val   (upd_val),
        .rd_sel    (rd_sel),
        .hide      (c_q.hidden),
        .rd_word   (rd_data),
        .key_zero  (key_zero),
        .wp_bit    (wp_bit)
    );

    assign hide_flag  = c_q.hidden;
    assign req_ready  = (c_q.phase == PH_IDLE);
    assign done       = (c_q.phase == PH_DONE);
    assign status     = c_q.status;
    assign fuse_valid = c_q.valid;
    assign key_blank  = c_q.valid && key_zero;
    assign locked     = c_q.valid && wp_bit;
    assign fuse_blow  = burn_active;
    assign fuse_sel   = c_q.idx;

endmodule

// File: rtl/fuse_prog_ctrl_chk.sv
module fuse_prog_ctrl_chk #(
    parameter int IDX_W = 8,
    parameter int PMAX  = 50000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             done,
    input logic             fuse_blow,
    input logic [IDX_W-1:0] fuse_sel,
    input logic             locked,
    input logic             fuse_valid,
    input logic             hidden
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= fuse_blow ? run_q + 32'd1 : 32'd0;
    end

    assert_settle_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_valid |-> !req_ready);

    assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_valid |=> fuse_valid);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_blow || done) |-> !req_ready);

    assert_sel_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_blow |=> (!fuse_blow || $stable(fuse_sel)));

    assert_pulse_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 32'(PMAX));

    assert_no_burn_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !fuse_blow);

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_hide_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hidden |=> hidden);

endmodule

bind fuse_prog_ctrl fuse_prog_ctrl_chk #(
    .IDX_W (IDX_W),
    .PMAX  (PULSE_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .fuse_blow  (fuse_blow),
    .fuse_sel   (fuse_sel),
    .locked     (locked),
    .fuse_valid (fuse_valid),
    .hidden     (hide_flag)
);

// File: tb/fuse_prog_ctrl_tb.sv
module fuse_prog_ctrl_tb_top;

    localparam int SETTLE = 8;
    localparam int SENSE  = 2;
    localparam int PMAX   = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [7:0]   req_idx = '0;
    logic [15:0]  pulse_cycles = '0;
    logic         done;
    logic [1:0]   status;
    logic         hide_req = 1'b0;
    logic [2:0]   rd_sel = '0;
    logic [31:0]  rd_data;
    logic         fuse_valid, key_blank, locked, fuse_blow;
    logic [7:0]   fuse_sel;
    logic [255:0] cells;
    logic [255:0] stubborn;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    logic [255:0] shadow_m;
    bit           hidden_m = 0;
    int           settle_m = 0;
    logic [7:0]   pend_idx = '0;
    bit           pend_on  = 0;

    always #10 clk = ~clk;

    fuse_prog_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .pulse_cycles(pulse_cycles), .done(done), .status(status),
        .hide_req(hide_req), .rd_sel(rd_sel), .rd_data(rd_data),
        .fuse_valid(fuse_valid), .key_blank(key_blank), .locked(locked),
        .fuse_blow(fuse_blow), .fuse_sel(fuse_sel), .fuse_sense(cells)
    );

    // Abstract fuse cells: a burn blows the addressed cell unless marked stubborn.
    always @(posedge clk)
        if (fuse_blow && !stubborn[fuse_sel]) cells[fuse_sel] <= 1'b1;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected<%0d", wd, 190000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One clock: advance, update the model for what the edge did, compare outputs.
    task automatic cyc();
        bit hp;
        bit vm;
        logic [31:0] exp_rd;
        hp = hide_req && rst_n;
        @(negedge clk);
        if (!rst_n) begin
            shadow_m = '0;
            hidden_m = 0;
            settle_m = 0;
        end else begin
            if (settle_m < SETTLE) begin
                settle_m++;
                if (settle_m == SETTLE) shadow_m = cells;
            end
            if (hp) hidden_m = 1;
            if (done && pend_on && status < 2) shadow_m[pend_idx] = cells[pend_idx];
        end
        vm = (settle_m >= SETTLE);
        exp_rd = hidden_m ? 32'd0 : shadow_m[rd_sel*32 +: 32];
        chk(fuse_valid == vm, "R1", "fuse_valid", fuse_valid, vm);
        chk(key_blank == (vm && (shadow_m[127:0] == '0)), "R7", "key_blank",
            key_blank, vm && (shadow_m[127:0] == '0));
        chk(locked == (vm && shadow_m[255]), "R5", "locked", locked, vm && shadow_m[255]);
        chk(rd_data == exp_rd, "R8", "rd_data", rd_data, exp_rd);
        rd_sel = rd_sel + 3'd1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        repeat (3) cyc();
        chk(req_ready == 1'b0, "R1", "ready during settle", req_ready, 0);
        chk(fuse_valid == 1'b0, "R1", "valid during settle", fuse_valid, 0);
        repeat (SETTLE - 3) cyc();
        chk(fuse_valid == 1'b1, "R1", "valid after settle", fuse_valid, 1);
        chk(req_ready == 1'b1, "R1", "ready after settle", req_ready, 1);
    endtask

    task automatic blow(input logic [7:0] idx, input int len_req,
                        input logic [1:0] exp_st, input string rq);
        int exp_len, exp_n, n, nb;
        exp_len = (len_req == 0) ? 1 : ((len_req > PMAX) ? PMAX : len_req);
        exp_n   = (exp_st < 2) ? (1 + exp_len + SENSE) : 1;
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid    = 1'b1;
        req_idx      = idx;
        pulse_cycles = 16'(len_req);
        pend_idx     = idx;
        pend_on      = 1;
        cyc();
        n = 1;
        req_valid = 1'b0;
        nb = 0;
        while (!done && n < 60000) begin
            if (fuse_blow && fuse_sel == idx) nb++;
            chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
            cyc();
            n++;
        end
        chk(n == exp_n, rq, "done edge", n, exp_n);
        chk(status == exp_st, rq, "status", status, exp_st);
        chk(nb == ((exp_st < 2) ? exp_len : 0), (exp_st < 2) ? "R3" : rq,
            "burn cycles", nb, (exp_st < 2) ? exp_len : 0);
        chk(req_ready == 1'b0, "R2", "ready during done", req_ready, 0);
        pend_on = 0;
        cyc();
        chk(done == 1'b0, "R2", "done width", done, 0);
        chk(req_ready == 1'b1, "R2", "ready after done", req_ready, 1);
    endtask

    initial begin
        cells    = '0;
        cells[200] = 1'b1;
        stubborn = '0;
        shadow_m = '0;

        do_reset();
        rd_sel = 3'd6;
        #1;
        chk(rd_data[8] == 1'b1, "R8", "pre-blown fuse 200 in word 6", rd_data, 32'h100);
        chk(key_blank == 1'b1, "R7", "blank key after reset", key_blank, 1);

        blow(8'd5, 3, 2'd0, "R4");
        chk(key_blank == 1'b0, "R7", "key no longer blank", key_blank, 0);
        blow(8'd130, 0, 2'd0, "R3");

        stubborn[40] = 1'b1;
        blow(8'd40, 4, 2'd1, "R4");
        stubborn[40] = 1'b0;
        blow(8'd40, 4, 2'd0, "R4");

        blow(8'd131, 60000, 2'd0, "R3");

        hide_req = 1'b1;
        cyc();
        hide_req = 1'b0;
        #1;
        chk(rd_data == 32'd0, "R6", "hidden read", rd_data, 0);
        blow(8'd6, 2, 2'd3, "R6");
        repeat (4) cyc();
        blow(8'd6, 2, 2'd3, "R6");

        do_reset();
        rd_sel = 3'd0;
        #1;
        chk(rd_data == 32'h20, "R9", "word 0 after reset", rd_data, 32'h20);
        rd_sel = 3'd1;
        #1;
        chk(rd_data == 32'h100, "R9", "word 1 after reset", rd_data, 32'h100);
        blow(8'd7, 2, 2'd0, "R9");

        blow(8'd255, 2, 2'd0, "R5");
        chk(locked == 1'b1, "R5", "locked after top fuse", locked, 1);
        blow(8'd8, 2, 2'd2, "R5");
        hide_req = 1'b1;
        cyc();
        hide_req = 1'b0;
        blow(8'd9, 2, 2'd2, "R6");
        chk(cells[9:8] == 2'b00, "R5", "refused fuses untouched", cells[9:8], 0);

        summary();
        $finish;
    end

endmodule